// File: doc/BRIEF.md
# Plug-and-Play Identification Register Slave

This block is a memory-mapped slave that answers inside a 4 KB window on a 64-bit single-beat bus. It uses valid/ready handshakes in the AXI4-Lite style. The bottom of the window holds fixed identification words for the chip: a hardware ID taken from a parameter, an information word, and the slot counts. It also holds a firmware ID and four 64-bit debug registers that firmware may read and write.

From byte offset 0x040 upward, software finds a packed table of device descriptors. The table is built from per-slot configuration inputs. Master entries are 8 bytes and slave entries are 16 bytes. The low byte of every entry gives its length in bytes. Software walks the table by adding that length to the current address.

Each transaction completes one cycle after its address is accepted, and only one is outstanding at a time. Every response is OKAY.

Top module: `pnp_id_slave`

## Requirements
- R1: After reset, bvalid and rvalid are low. The firmware ID and all four debug registers read as zero.
- R2: A read of the word at 0x000 returns the HW_ID parameter in bits 31:0 and the firmware ID in bits 63:32. The firmware ID sits at byte offset 0x004, in the upper half of the data lane.
- R3: A read of the word at 0x008 returns the following, with bits 63:32 zero:
  - bits 7:0: TECH_ID
  - bits 15:8: N_SLV
  - bits 23:16: N_MST
  - bits 31:24: the adc_detect input
- R4: A write to the word at 0x000 updates firmware ID byte k only when wstrb[4+k] is set. wstrb[3:0] and the hardware ID are never changed by a write.
- R5: The words at 0x010, 0x018, 0x020 and 0x028 are 64-bit debug registers. A write updates byte k of the addressed register only when wstrb[k] is set.
- R6: Master slot m has its descriptor word at 0x040 + 8*m. Bits 7:0 = 0x08, bits 9:8 = 2'b01, bits 31:10 = 0, bits 47:32 = device ID, bits 63:48 = vendor ID. Slot k of a packed 16-bit configuration bus uses bits 16k+15:16k.
- R7: Slave slot s starts at 0x040 + 8*N_MST + 16*s and spans two words.
  - First word: bits 7:0 = 0x10, bits 9:8 = 2'b10, IRQ index in 23:16, device ID in 47:32, vendor ID in 63:48, all other bits zero.
  - Second word: address mask in 31:12 and base address in 63:44, all other bits zero.
  - IRQ slot k uses bits 8k+7:8k. Mask and base slot k use bits 20k+19:20k.
- R8: Writes to read-only words, to the descriptor table and to unmapped offsets still give bvalid with bresp 2'b00. They change no readable state.
- R9: Reads of unmapped words return zero. This covers 0x030, 0x038, and everything past the last descriptor.
- R10: A response goes valid in the cycle after its request is accepted and stays valid until taken. While a response is pending, no request is accepted.
- R11: When awvalid and wvalid are both high together with arvalid, the write is accepted first. Address bits 2:0 are ignored. All responses carry code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| awaddr | input | 12 | Write byte address within the window |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| wdata | input | 64 | Write data |
| wstrb | input | 8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| araddr | input | 12 | Read byte address within the window |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| rdata | output | 64 | Read data |
| rresp | output | 2 | Read response code |
| adc_detect | input | 8 | Clock-detect byte shown in the information word |
| mst_dev_id | input | 16*N_MST | Device ID for each master slot |
| mst_vendor_id | input | 16*N_MST | Vendor ID for each master slot |
| slv_dev_id | input | 16*N_SLV | Device ID for each slave slot |
| slv_vendor_id | input | 16*N_SLV | Vendor ID for each slave slot |
| slv_irq | input | 8*N_SLV | IRQ index for each slave slot |
| slv_mask | input | 20*N_SLV | Address mask for each slave slot |
| slv_base | input | 20*N_SLV | Base address for each slave slot |

## Verification
The reads cover several kinds of word:
- the identification words, where the fixed half and the writable half are told apart;
- every descriptor word, including the master/slave boundary and the first word past the table, which exposes any off-by-one in the offset arithmetic;
- the gap words at 0x030 and 0x038.

Writes use full strobes, single-byte strobes and strobes aimed only at the read-only half. This shows whether byte masking and the half-lane placement of the firmware ID are right. Writes to read-only, descriptor and unmapped words are each followed by readback, so ignored writes are confirmed at the ports. Responses are also held back and read and write requests are raised together. Together these separate a correct handshake from one that drops held responses, accepts during a pending response, or lets the read win.

// File: rtl/pnp_pkg.sv
package pnp_pkg;
  localparam int ADDR_W         = 12;
  localparam int WORD_IDX_W     = ADDR_W - 3;
  localparam int DESC_BASE_WORD = 8;   // byte offset 0x040
  localparam int DBG_BASE_WORD  = 2;   // byte offset 0x010
  localparam int N_DBG          = 4;

  localparam logic [1:0] KIND_MST = 2'b01;
  localparam logic [1:0] KIND_SLV = 2'b10;
  localparam logic [7:0] LEN_MST  = 8'h08;
  localparam logic [7:0] LEN_SLV  = 8'h10;

  function automatic logic [63:0] mst_desc(input logic [15:0] dev, input logic [15:0] vend);
    return {vend, dev, 22'h0, KIND_MST, LEN_MST};
  endfunction

  function automatic logic [63:0] slv_desc_lo(input logic [7:0] irq, input logic [15:0] dev,
                                              input logic [15:0] vend);
    return {vend, dev, 8'h0, irq, 6'h0, KIND_SLV, LEN_SLV};
  endfunction

  function automatic logic [63:0] slv_desc_hi(input logic [19:0] mask, input logic [19:0] base);
    return {base, 12'h0, mask, 12'h0};
  endfunction

  // word index of a descriptor word, counted from the start of the window
  function automatic int mst_word_idx(input int m);
    return DESC_BASE_WORD + m;
  endfunction

  function automatic int slv_word_idx(input int n_mst, input int s);
    return DESC_BASE_WORD + n_mst + 2 * s;
  endfunction

  function automatic logic [63:0] merge_bytes(input logic [63:0] old_v, input logic [63:0] new_v,
                                              input logic [7:0] strb);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] merge_half(input logic [31:0] old_v, input logic [31:0] new_v,
                                             input logic [3:0] strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pnp_handshake.sv
module pnp_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic awvalid,
  input  logic wvalid,
  input  logic arvalid,
  input  logic bready,
  input  logic rready,
  output logic wr_ready,
  output logic rd_ready,
  output logic wr_fire,
  output logic rd_fire,
  output logic bvalid,
  output logic rvalid
);
  logic busy;
  logic wr_req;

  assign busy     = bvalid || rvalid;
  assign wr_req   = awvalid && wvalid;
  assign wr_ready = !busy && wr_req;
  assign rd_ready = !busy && !wr_req;
  assign wr_fire  = wr_ready;
  assign rd_fire  = rd_ready && arvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      if (wr_fire)     bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;
      if (rd_fire)     rvalid <= 1'b1;
      else if (rready) rvalid <= 1'b0;
    end
  end

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(bvalid && rvalid));
  a_r10_wr_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bvalid);
  a_r10_rd_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid);
  a_r10_b_held: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  a_r10_r_held: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid);
  a_r11_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> !(awvalid && wvalid));
endmodule

// File: rtl/pnp_scratch.sv
module pnp_scratch
  import pnp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [WORD_IDX_W-1:0] wr_word,
  input  logic [63:0]           wdata,
  input  logic [7:0]            wstrb,
  output logic [31:0]           fw_id,
  output logic [63:0]           dbg [N_DBG]
);
  logic fw_sel;
  assign fw_sel = wr_fire && (wr_word == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) fw_id <= '0;
    else if (fw_sel) fw_id <= merge_half(fw_id, wdata[63:32], wstrb[7:4]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_DBG; i++) begin
      if (!rst_n) dbg[i] <= '0;
      else if (wr_fire && wr_word == WORD_IDX_W'(DBG_BASE_WORD + i))
        dbg[i] <= merge_bytes(dbg[i], wdata, wstrb);
    end
  end

  a_r4_low_strobe_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    fw_sel && wstrb[7:4] == 4'h0 |=> $stable(fw_id));
  a_r8_fw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_sel |=> $stable(fw_id));

  for (genvar g = 0; g < N_DBG; g++) begin : g_dbg_chk
    a_r8_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_fire && wr_word == WORD_IDX_W'(DBG_BASE_WORD + g)) |=> $stable(dbg[g]));
  end
endmodule

// File: rtl/pnp_desc_rom.sv
module pnp_desc_rom
  import pnp_pkg::*;
#(
  parameter int N_MST = 2,
  parameter int N_SLV = 3
) (
  input  logic [WORD_IDX_W-1:0] rd_word,
  input  logic [16*N_MST-1:0]   mst_dev_id,
  input  logic [16*N_MST-1:0]   mst_vendor_id,
  input  logic [16*N_SLV-1:0]   slv_dev_id,
  input  logic [16*N_SLV-1:0]   slv_vendor_id,
  input  logic [8*N_SLV-1:0]    slv_irq,
  input  logic [20*N_SLV-1:0]   slv_mask,
  input  logic [20*N_SLV-1:0]   slv_base,
  output logic                  hit,
  output logic [63:0]           word
);
  localparam int N_WORDS = N_MST + 2 * N_SLV;

  logic [63:0] tbl [N_WORDS];

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    assign tbl[mst_word_idx(m) - DESC_BASE_WORD] =
      mst_desc(mst_dev_id[16*m +: 16], mst_vendor_id[16*m +: 16]);
  end

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    localparam int LO = slv_word_idx(N_MST, s) - DESC_BASE_WORD;
    assign tbl[LO]     = slv_desc_lo(slv_irq[8*s +: 8], slv_dev_id[16*s +: 16],
                                     slv_vendor_id[16*s +: 16]);
    assign tbl[LO + 1] = slv_desc_hi(slv_mask[20*s +: 20], slv_base[20*s +: 20]);
  end

  always_comb begin
    hit  = 1'b0;
    word = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      if (rd_word == WORD_IDX_W'(DESC_BASE_WORD + i)) begin
        hit  = 1'b1;
        word = tbl[i];
      end
    end
  end
endmodule

// File: rtl/pnp_id_slave.sv
module pnp_id_slave
  import pnp_pkg::*;
#(
  parameter int          N_MST   = 2,
  parameter int          N_SLV   = 3,
  parameter logic [31:0] HW_ID   = 32'h2024_0517,
  parameter logic [7:0]  TECH_ID = 8'h02
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic                 wvalid,
  output logic                 wready,
  input  logic [63:0]          wdata,
  input  logic [7:0]           wstrb,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [1:0]           bresp,
  input  logic                 arvalid,
  output logic                 arready,
  input  logic [ADDR_W-1:0]    araddr,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [63:0]          rdata,
  output logic [1:0]           rresp,
  input  logic [7:0]           adc_detect,
  input  logic [16*N_MST-1:0]  mst_dev_id,
  input  logic [16*N_MST-1:0]  mst_vendor_id,
  input  logic [16*N_SLV-1:0]  slv_dev_id,
  input  logic [16*N_SLV-1:0]  slv_vendor_id,
  input  logic [8*N_SLV-1:0]   slv_irq,
  input  logic [20*N_SLV-1:0]  slv_mask,
  input  logic [20*N_SLV-1:0]  slv_base
);
  logic                  wr_ready, wr_fire, rd_fire;
  logic [WORD_IDX_W-1:0] wr_word, rd_word;
  logic [31:0]           fw_id;
  logic [63:0]           dbg [N_DBG];
  logic                  desc_hit;
  logic [63:0]           desc_word;
  logic [63:0]           rd_mux;
  logic [63:0]           rdata_q;

  assign wr_word = awaddr[ADDR_W-1:3];
  assign rd_word = araddr[ADDR_W-1:3];

  pnp_handshake u_hs (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .wvalid(wvalid), .arvalid(arvalid),
    .bready(bready), .rready(rready),
    .wr_ready(wr_ready), .rd_ready(arready),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .bvalid(bvalid), .rvalid(rvalid)
  );

  assign awready = wr_ready;
  assign wready  = wr_ready;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;

  pnp_scratch u_scr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_word(wr_word),
    .wdata(wdata), .wstrb(wstrb), .fw_id(fw_id), .dbg(dbg)
  );

  pnp_desc_rom #(.N_MST(N_MST), .N_SLV(N_SLV)) u_rom (
    .rd_word(rd_word),
    .mst_dev_id(mst_dev_id), .mst_vendor_id(mst_vendor_id),
    .slv_dev_id(slv_dev_id), .slv_vendor_id(slv_vendor_id),
    .slv_irq(slv_irq), .slv_mask(slv_mask), .slv_base(slv_base),
    .hit(desc_hit), .word(desc_word)
  );

  always_comb begin
    rd_mux = desc_word;
    if (rd_word == '0)
      rd_mux = {fw_id, HW_ID};
    else if (rd_word == WORD_IDX_W'(1))
      rd_mux = {32'h0, adc_detect, 8'(N_MST), 8'(N_SLV), TECH_ID};
    else
      for (int i = 0; i < N_DBG; i++)
        if (rd_word == WORD_IDX_W'(DBG_BASE_WORD + i)) rd_mux = dbg[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_mux;
  end
  assign rdata = rdata_q;

  a_r2_hw_id_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && rd_word == '0 |=> rdata[31:0] == HW_ID);
  a_r3_slot_counts: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && rd_word == WORD_IDX_W'(1) |=> rdata[23:8] == {8'(N_MST), 8'(N_SLV)});
  a_r9_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && (rd_word == WORD_IDX_W'(6) || rd_word == WORD_IDX_W'(7)) |=> rdata == '0);
  a_r6_table_kind: assert property (@(posedge clk) disable iff (!rst_n)
    desc_hit && rd_fire && rd_word == WORD_IDX_W'(DESC_BASE_WORD) && N_MST > 0
      |=> rdata[9:0] == {KIND_MST, LEN_MST});
  a_r11_sub_word_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && araddr[2:0] != 3'b0 |=> rvalid);
  a_r11_sub_word_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && awaddr[2:0] != 3'b0 |=> bvalid);
endmodule

// File: tb/pnp_id_slave_bench.sv
`timescale 1ns/1ps
module pnp_id_slave_bench;
  localparam int          NM   = 2;
  localparam int          NS   = 3;
  localparam logic [31:0] HWID = 32'h2024_0517;
  localparam logic [7:0]  TECH = 8'h02;
  localparam time         TCK  = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [11:0] awaddr = 0, araddr = 0;
  logic [63:0] wdata = 0;
  logic [7:0]  wstrb = 0;
  logic [7:0]  adc = 8'h5A;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [63:0] rdata;

  logic [15:0] mdev [NM] = '{16'h1001, 16'h1002};
  logic [15:0] mven [NM] = '{16'hC0DE, 16'hBEEF};
  logic [15:0] sdev [NS] = '{16'h2001, 16'h2002, 16'h2003};
  logic [15:0] sven [NS] = '{16'hFACE, 16'hCAFE, 16'hD00D};
  logic [7:0]  sirq [NS] = '{8'd3, 8'd7, 8'd12};
  logic [19:0] smsk [NS] = '{20'hFFFF0, 20'hFFFFE, 20'hFF000};
  logic [19:0] sbas [NS] = '{20'h80000, 20'h80010, 20'h90000};

  logic [16*NM-1:0] p_mdev, p_mven;
  logic [16*NS-1:0] p_sdev, p_sven;
  logic [8*NS-1:0]  p_sirq;
  logic [20*NS-1:0] p_smsk, p_sbas;
  always_comb begin
    for (int k = 0; k < NM; k++) begin
      p_mdev[16*k +: 16] = mdev[k];
      p_mven[16*k +: 16] = mven[k];
    end
    for (int k = 0; k < NS; k++) begin
      p_sdev[16*k +: 16] = sdev[k];
      p_sven[16*k +: 16] = sven[k];
      p_sirq[8*k +: 8]   = sirq[k];
      p_smsk[20*k +: 20] = smsk[k];
      p_sbas[20*k +: 20] = sbas[k];
    end
  end

  pnp_id_slave #(.N_MST(NM), .N_SLV(NS), .HW_ID(HWID), .TECH_ID(TECH)) u_pnp_id_slave (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .adc_detect(adc),
    .mst_dev_id(p_mdev), .mst_vendor_id(p_mven),
    .slv_dev_id(p_sdev), .slv_vendor_id(p_sven),
    .slv_irq(p_sirq), .slv_mask(p_smsk), .slv_base(p_sbas)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_fw;
  logic [63:0] m_dbg [4];
  bit          m_b, m_r;
  logic [63:0] m_rd;

  // walk the table by byte length, the way software would
  function automatic logic [63:0] ref_read(input logic [11:0] addr);
    logic [11:0] a;
    int off;
    logic [63:0] w;
    a = addr & 12'hFF8;
    if (a == 12'h000) return {m_fw, HWID};
    if (a == 12'h008) return {32'h0, adc, 8'(NM), 8'(NS), TECH};
    if (a >= 12'h010 && a <= 12'h028) return m_dbg[(a - 12'h010) / 8];
    off = 'h40;
    for (int m = 0; m < NM; m++) begin
      if (int'(a) == off) begin
        w = '0; w[7:0] = 8'd8; w[9:8] = 2'b01; w[47:32] = mdev[m]; w[63:48] = mven[m];
        return w;
      end
      off += 8;
    end
    for (int s = 0; s < NS; s++) begin
      if (int'(a) == off) begin
        w = '0; w[7:0] = 8'd16; w[9:8] = 2'b10; w[23:16] = sirq[s];
        w[47:32] = sdev[s]; w[63:48] = sven[s];
        return w;
      end
      if (int'(a) == off + 8) begin
        w = '0; w[31:12] = smsk[s]; w[63:44] = sbas[s];
        return w;
      end
      off += 16;
    end
    return '0;
  endfunction

  function automatic string tag_of(input logic [11:0] addr);
    logic [11:0] a;
    a = addr & 12'hFF8;
    if (a == 12'h000) return "R2";
    if (a == 12'h008) return "R3";
    if (a <= 12'h028) return "R5";
    if (a < 12'h040) return "R9";
    if (a < 12'h040 + 8*NM) return "R6";
    if (a < 12'h040 + 8*NM + 16*NS) return "R7";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fw <= '0; m_b <= 0; m_r <= 0; m_rd <= '0;
      for (int i = 0; i < 4; i++) m_dbg[i] <= '0;
    end else begin
      if (m_b && bready) m_b <= 0;
      if (m_r && rready) m_r <= 0;
      if (!(m_b || m_r) && awvalid && wvalid) begin
        m_b <= 1;
        if ((awaddr & 12'hFF8) == 12'h000)
          for (int k = 0; k < 4; k++) if (wstrb[4+k]) m_fw[8*k +: 8] <= wdata[32+8*k +: 8];
        for (int i = 0; i < 4; i++)
          if ((awaddr & 12'hFF8) == 12'h010 + 12'(8*i))
            for (int k = 0; k < 8; k++) if (wstrb[k]) m_dbg[i][8*k +: 8] <= wdata[8*k +: 8];
      end else if (!(m_b || m_r) && arvalid) begin
        m_r  <= 1;
        m_rd <= ref_read(araddr);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bvalid == m_b, "R10 bvalid", 64'(bvalid), 64'(m_b));
      chk(rvalid == m_r, "R10 rvalid", 64'(rvalid), 64'(m_r));
      chk(awready == (!(m_b || m_r) && awvalid && wvalid), "R11 awready", 64'(awready),
          64'(!(m_b || m_r) && awvalid && wvalid));
      chk(wready == awready, "R11 wready", 64'(wready), 64'(awready));
      chk(arready == (!(m_b || m_r) && !(awvalid && wvalid)), "R11 arready", 64'(arready),
          64'(!(m_b || m_r) && !(awvalid && wvalid)));
      if (rvalid && m_r) chk(rdata == m_rd, {tag_of(araddr), " model rdata"}, rdata, m_rd);
      chk(bresp == 2'b00 && rresp == 2'b00, "R11 resp", 64'({bresp, rresp}), 64'h0);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic do_read(input logic [11:0] addr, input logic [63:0] exp, input string tag);
    @(negedge clk);
    araddr = addr; arvalid = 1; rready = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 0;
    chk(rvalid === 1'b1, {tag, " rvalid one cycle after accept"}, 64'(rvalid), 64'h1);
    chk(rdata === exp, {tag, " rdata"}, rdata, exp);
  endtask

  task automatic do_write(input logic [11:0] addr, input logic [63:0] d, input logic [7:0] s,
                          input string tag);
    @(negedge clk);
    awaddr = addr; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk(bvalid === 1'b1 && bresp == 2'b00, {tag, " bvalid okay"}, 64'({bvalid, bresp}), 64'h4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!bvalid && !rvalid, "R1 no response after reset", 64'({bvalid, rvalid}), 64'h0);
    do_read(12'h000, {32'h0, HWID}, "R1");
    for (int i = 0; i < 4; i++) do_read(12'h010 + 12'(8*i), 64'h0, "R1");
    // R3 info word, R11 sub-word address
    do_read(12'h008, {32'h0, adc, 8'd2, 8'd3, TECH}, "R3");
    do_read(12'h00C, {32'h0, adc, 8'd2, 8'd3, TECH}, "R11");
    adc = 8'hA7;
    do_read(12'h008, {32'h0, 8'hA7, 8'd2, 8'd3, TECH}, "R3");
    // R4 firmware ID
    do_write(12'h004, 64'h1234_5678_FFFF_FFFF, 8'hFF, "R4");
    do_read(12'h000, {32'h1234_5678, HWID}, "R4");
    do_write(12'h000, 64'hAAAA_BBBB_CCCC_DDDD, 8'h20, "R4");
    do_read(12'h000, {32'h1234_BB78, HWID}, "R4");
    do_write(12'h000, 64'h0, 8'h0F, "R4");
    do_read(12'h000, {32'h1234_BB78, HWID}, "R4");
    // R5 debug registers
    do_write(12'h010, 64'h0102_0304_0506_0708, 8'hFF, "R5");
    do_write(12'h028, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, "R5");
    do_write(12'h01B, 64'h1111_2222_3333_4444, 8'h0C, "R5");
    do_read(12'h010, 64'h0102_0304_0506_0708, "R5");
    do_read(12'h018, 64'h0000_0000_3333_0000, "R5");
    do_read(12'h020, 64'h0, "R5");
    do_read(12'h028, 64'hFF00_0000_0000_00FF, "R5");
    // R6/R7 descriptors, R9 unmapped
    for (int a = 'h40; a < 'h80; a += 8) do_read(12'(a), ref_read(12'(a)), tag_of(12'(a)));
    do_read(12'h040, {mven[0], mdev[0], 22'h0, 2'b01, 8'h08}, "R6");
    do_read(12'h050, {sven[0], sdev[0], 8'h0, sirq[0], 6'h0, 2'b10, 8'h10}, "R7");
    do_read(12'h078, {sbas[2], 12'h0, smsk[2], 12'h0}, "R7");
    do_read(12'h080, 64'h0, "R9");
    do_read(12'h030, 64'h0, "R9");
    do_read(12'h038, 64'h0, "R9");
    do_read(12'hFF8, 64'h0, "R9");
    // R8 ignored writes
    do_write(12'h008, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R8");
    do_write(12'h048, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R8");
    do_write(12'h058, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R8");
    do_write(12'h030, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R8");
    do_read(12'h008, {32'h0, 8'hA7, 8'd2, 8'd3, TECH}, "R8");
    do_read(12'h048, {mven[1], mdev[1], 22'h0, 2'b01, 8'h08}, "R8");
    do_read(12'h058, {sbas[0], 12'h0, smsk[0], 12'h0}, "R8");
    do_read(12'h030, 64'h0, "R8");
    do_read(12'h000, {32'h1234_BB78, HWID}, "R8");
    // R10 back-pressure on a read
    @(negedge clk);
    araddr = 12'h008; arvalid = 1; rready = 0;
    @(negedge clk);
    arvalid = 1; araddr = 12'h010;
    repeat (3) begin
      @(negedge clk);
      chk(rvalid && !arready, "R10 held read blocks new request", 64'({rvalid, arready}), 64'h2);
    end
    rready = 1;
    @(negedge clk);
    chk(!rvalid, "R10 read response taken", 64'(rvalid), 64'h0);
    @(negedge clk);
    arvalid = 0;
    chk(rvalid && rdata == 64'h0102_0304_0506_0708, "R10 second read after release", rdata,
        64'h0102_0304_0506_0708);
    @(negedge clk);
    // R10 back-pressure on a write
    awaddr = 12'h020; wdata = 64'h5; wstrb = 8'hFF; awvalid = 1; wvalid = 1; bready = 0;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    repeat (3) begin
      @(negedge clk);
      chk(bvalid, "R10 write response held", 64'(bvalid), 64'h1);
    end
    bready = 1;
    @(negedge clk);
    chk(!bvalid, "R10 write response taken", 64'(bvalid), 64'h0);
    // R11 write wins over read
    awaddr = 12'h020; wdata = 64'h77; wstrb = 8'h01; awvalid = 1; wvalid = 1;
    araddr = 12'h020; arvalid = 1; rready = 1;
    #1;
    chk(awready && !arready, "R11 write accepted first", 64'({awready, arready}), 64'h2);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk(bvalid && !rvalid, "R11 write response first", 64'({bvalid, rvalid}), 64'h2);
    @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    chk(rvalid && rdata == 64'h77, "R11 read after write sees new data", rdata, 64'h77);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(TCK * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule